// File: doc/BRIEF.md
# Receive Sampling Tap Tuning Engine

This block searches for the best receive sampling delay in a card interface. A single start strobe makes it turn on the input tap delay and then sweep every tap setting in ascending order. At each setting it asks an external command engine to run one tuning test and takes back a pass or fail verdict. While it sweeps, it keeps the verdict of the previous tap, the tap at which the most recent fail-to-pass change happened, and a count of failing taps.

After the last tap it works out how long the passing region is (the tap count less the failures). It then programs the tap that lies half that length past the recorded start, wrapping around the tap ring. This places the sample point inside a passing window even when that window crosses from the highest tap back to tap 0. Every tap load uses a three-step sequence. A change window opens, the tap value is loaded while the window is open, and the window then closes. The block ends by raising a one-cycle done pulse and shows the chosen tap on an output.

Top module: `tap_tune_engine`

## Requirements
- R1: After synchronous reset, tap_en, tap_win, test_req and done are 0, and tap_sel and final_tap are 0.
- R2: A start pulse in the idle state sets tap_en before the first tap load begins. tap_en stays 1 from then on.
- R3: Taps 0 to 31 are each tested exactly once, in increasing order. Each tap is loaded before test_req is raised for it.
- R4: Every tap load opens tap_win for two cycles. tap_sel changes only while tap_win is 1, and tap_win is 0 while test_req is high. A full run opens the window 33 times: 32 sweep loads and 1 final load.
- R5: test_req stays high until a cycle in which test_ack is 1. test_pass is sampled in that cycle (1 = pass), and test_req is 0 in the following cycle.
- R6: The previous verdict starts as pass at each run. The window start is the last tap whose verdict is pass when the verdict of the tap before it was fail. It stays 0 if no such tap exists.
- R7: The final tap is (window start + (32 - fail count) / 2) mod 32, where the division rounds down.
- R8: If every tap passes, the final tap is 16.
- R9: If every tap fails, the final tap is 0.
- R10: done is high for exactly one cycle, after the final tap load has closed its window. At that point tap_sel and final_tap both equal the final tap.
- R11: A start pulse while a run is in progress is ignored. The sweep continues in order and produces exactly one done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a tuning run when idle |
| test_ack | input | 1 | Tuning test finished, verdict valid |
| test_pass | input | 1 | Verdict of the test, 1 = pass |
| tap_en | output | 1 | Input tap delay enable |
| tap_sel | output | 5 | Programmed receive tap |
| tap_win | output | 1 | Tap change window |
| test_req | output | 1 | Tuning test request |
| done | output | 1 | One-cycle run-complete pulse |
| final_tap | output | 5 | Chosen tap of the last run |

## Verification
The assertions assume that test_ack only arrives while test_req is high, that it lasts a single cycle, and that test_pass is valid in that cycle. The bench responder waits for a rising request and lets a varying number of cycles pass before answering. It drops test_ack on the next cycle, and it reads the verdict from the tap the block has programmed at that moment. Start pulses are single cycles, and one of them is deliberately sent in the middle of a sweep.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_CALC,
    ST_FINAL
  } tune_state_t;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_OPEN,
    LD_CLOSE
  } load_state_t;
endpackage

// File: rtl/tap_loader.sv
module tap_loader #(
  parameter int TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [TAP_BITS-1:0] val,
  output logic [TAP_BITS-1:0] tap_sel,
  output logic                tap_win,
  output logic                loaded
);
  import tap_tune_pkg::*;

  load_state_t         st;
  logic [TAP_BITS-1:0] val_q;

  // open window, load value, close window
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= LD_IDLE;
      val_q   <= '0;
      tap_sel <= '0;
      tap_win <= 1'b0;
      loaded  <= 1'b0;
    end else begin
      loaded <= 1'b0;
      case (st)
        LD_IDLE: if (go) begin
          val_q   <= val;
          tap_win <= 1'b1;
          st      <= LD_OPEN;
        end
        LD_OPEN: begin
          tap_sel <= val_q;
          st      <= LD_CLOSE;
        end
        LD_CLOSE: begin
          tap_win <= 1'b0;
          loaded  <= 1'b1;
          st      <= LD_IDLE;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/window_tracker.sv
module window_tracker #(
  parameter int TAP_BITS = 5,
  parameter int NTAPS    = 1 << TAP_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                rec,
  input  logic                pass,
  input  logic [TAP_BITS-1:0] idx,
  output logic [TAP_BITS-1:0] centre
);
  localparam int CW = TAP_BITS + 1;

  logic          prev_pass;
  logic [TAP_BITS-1:0] win_start;
  logic [CW-1:0] fail_cnt;
  logic [CW-1:0] pass_len;
  logic [CW-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_pass <= 1'b1;
      win_start <= '0;
      fail_cnt  <= '0;
    end else if (rec) begin
      if (pass && !prev_pass) win_start <= idx;
      if (!pass) fail_cnt <= fail_cnt + 1'b1;
      prev_pass <= pass;
    end
  end

  // centre on the circular tap ring: truncation performs the modulo
  always_comb begin
    pass_len = CW'(NTAPS) - fail_cnt;
    sum      = {1'b0, win_start} + (pass_len >> 1);
    centre   = sum[TAP_BITS-1:0];
  end
endmodule

// File: rtl/tap_tune_engine.sv
module tap_tune_engine #(
  parameter int TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                test_ack,
  input  logic                test_pass,
  output logic                tap_en,
  output logic [TAP_BITS-1:0] tap_sel,
  output logic                tap_win,
  output logic                test_req,
  output logic                done,
  output logic [TAP_BITS-1:0] final_tap
);
  import tap_tune_pkg::*;

  localparam int NTAPS = 1 << TAP_BITS;
  localparam logic [TAP_BITS-1:0] LAST = TAP_BITS'(NTAPS - 1);

  tune_state_t         st;
  logic [TAP_BITS-1:0] idx;
  logic                wr_go;
  logic [TAP_BITS-1:0] wr_val;
  logic                loaded;
  logic                trk_clr;
  logic                trk_rec;
  logic [TAP_BITS-1:0] centre;

  always_comb begin
    trk_clr = (st == ST_IDLE) && start;
    trk_rec = (st == ST_WAIT) && test_ack;
    wr_go   = trk_clr || (trk_rec && idx != LAST) || (st == ST_CALC);
    if (st == ST_CALC)      wr_val = centre;
    else if (st == ST_WAIT) wr_val = idx + 1'b1;
    else                    wr_val = '0;
  end

  tap_loader #(.TAP_BITS(TAP_BITS)) u_loader (
    .clk     (clk),
    .rst     (rst),
    .go      (wr_go),
    .val     (wr_val),
    .tap_sel (tap_sel),
    .tap_win (tap_win),
    .loaded  (loaded)
  );

  window_tracker #(.TAP_BITS(TAP_BITS), .NTAPS(NTAPS)) u_track (
    .clk    (clk),
    .rst    (rst),
    .clr    (trk_clr),
    .rec    (trk_rec),
    .pass   (test_pass),
    .idx    (idx),
    .centre (centre)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      tap_en    <= 1'b0;
      test_req  <= 1'b0;
      done      <= 1'b0;
      final_tap <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          tap_en <= 1'b1;
          idx    <= '0;
          st     <= ST_LOAD;
        end
        ST_LOAD: if (loaded) begin
          test_req <= 1'b1;
          st       <= ST_WAIT;
        end
        ST_WAIT: if (test_ack) begin
          test_req <= 1'b0;
          if (idx == LAST) begin
            st <= ST_CALC;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_LOAD;
          end
        end
        ST_CALC: begin
          final_tap <= centre;
          st        <= ST_FINAL;
        end
        ST_FINAL: if (loaded) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tap_tune_checker.sv
module tap_tune_checker #(
  parameter int TAP_BITS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                test_ack,
  input logic                tap_en,
  input logic [TAP_BITS-1:0] tap_sel,
  input logic                tap_win,
  input logic                test_req,
  input logic                done,
  input logic [TAP_BITS-1:0] final_tap
);
  assert_tap_en_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    tap_en |=> tap_en);

  assert_sel_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(tap_sel) |-> tap_win);

  assert_req_window_closed_R4: assert property (@(posedge clk) disable iff (rst)
    test_req |-> (!tap_win && tap_en));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (test_req && !test_ack) |=> test_req);

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (test_req && test_ack) |=> !test_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_settled_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tap_win && final_tap == tap_sel && !test_req));
endmodule

bind tap_tune_engine tap_tune_checker #(.TAP_BITS(TAP_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .test_ack  (test_ack),
  .tap_en    (tap_en),
  .tap_sel   (tap_sel),
  .tap_win   (tap_win),
  .test_req  (test_req),
  .done      (done),
  .final_tap (final_tap)
);

// File: tb/tb_tap_tune_engine.sv
module tb_tap_tune_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       test_ack = 1'b0;
  logic       test_pass = 1'b0;
  logic       tap_en, tap_win, test_req, done;
  logic [4:0] tap_sel, final_tap;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [31:0] pat = '1;
  int exp_q[$];
  int exp_idx = 0;
  int win_opens = 0;

  always #10 clk = ~clk;

  tap_tune_engine dut (
    .clk(clk), .rst(rst), .start(start), .test_ack(test_ack),
    .test_pass(test_pass), .tap_en(tap_en), .tap_sel(tap_sel),
    .tap_win(tap_win), .test_req(test_req), .done(done),
    .final_tap(final_tap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [31:0] p);
    int prev = 1;
    int wstart = 0;
    int fails = 0;
    for (int t = 0; t < 32; t++) begin
      if (p[t] && prev == 0) wstart = t;
      if (!p[t]) fails++;
      prev = p[t];
    end
    return (wstart + ((32 - fails) >> 1)) % 32;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: push expectation, launch run, wait for monitor to consume it
  task automatic run_case(input logic [31:0] p, input bit busy_start);
    pat = p;
    exp_q.push_back(model(p));
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tap_en === 1'b1, "R2 tap_en after start", tap_en, 1);
    if (busy_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;          // R11: must be ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // responder for the external test engine
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (test_req && !test_ack) begin
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk(test_req === 1'b1, "R5 request held", test_req, 1);
        end
        test_pass = pat[tap_sel];
        test_ack  = 1'b1;
        @(negedge clk);
        test_ack  = 1'b0;
        chk(test_req === 1'b0, "R5 request dropped after ack", test_req, 0);
        dly = (dly + 1) % 4;
      end
    end
  end

  // monitor: sweep order, window discipline, scoreboard at done
  initial begin
    logic       req_d = 1'b0;
    logic       win_d = 1'b0;
    logic [4:0] sel_d = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (tap_sel !== sel_d && !tap_win)
          chk(1'b0, "R4 tap_sel changed with window closed", tap_sel, sel_d);
        if (tap_win && !win_d) win_opens++;
        if (test_req && !req_d) begin
          chk(tap_sel == exp_idx[4:0] && exp_idx < 32, "R3 tap under test",
              tap_sel, exp_idx);
          chk(tap_win === 1'b0, "R4 window closed at request", tap_win, 0);
          exp_idx++;
        end
        if (done) begin
          int e;
          e = (exp_q.size() != 0) ? exp_q.pop_front() : -1;
          chk(final_tap == e[4:0] && e >= 0, "R7 final tap", final_tap, e);
          chk(tap_sel == e[4:0], "R10 programmed tap at done", tap_sel, e);
          chk(tap_win === 1'b0, "R10 window closed at done", tap_win, 0);
          chk(exp_idx == 32, "R3 R11 taps tested per run", exp_idx, 32);
          chk(win_opens == 33, "R4 window openings per run", win_opens, 33);
          exp_idx   = 0;
          win_opens = 0;
          @(negedge clk);
          chk(done === 1'b0, "R10 done single cycle", done, 0);
        end
      end
      req_d = test_req;
      win_d = tap_win;
      sel_d = tap_sel;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog expired", cycles, 150000);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tap_en === 1'b0 && tap_win === 1'b0, "R1 enable and window", {tap_en, tap_win}, 0);
    chk(test_req === 1'b0 && done === 1'b0, "R1 request and done", {test_req, done}, 0);
    chk(tap_sel === 5'd0 && final_tap === 5'd0, "R1 tap outputs", tap_sel, 0);

    run_case(32'hFFFF_FFFF, 1'b0);  // R8: all pass -> 16
    run_case(32'h0000_0000, 1'b0);  // R9: all fail -> 0
    run_case(32'hF000_000F, 1'b0);  // R6 R7: wrapping window -> 0
    run_case(32'h0000_1C1F, 1'b0);  // R6: last fail-to-pass wins -> 14
    run_case(32'h8000_0000, 1'b0);  // R6: single pass at top -> 31
    run_case(32'h0000_0001, 1'b0);  // R6: pass at tap 0 only -> 0
    run_case(32'h00FF_FF00, 1'b1);  // R11: start while busy -> 16
    for (int i = 0; i < 6; i++) begin
      p = $urandom();
      run_case(p, 1'b0);            // R7 mixed patterns
    end
    chk(exp_q.size() == 0, "R10 every run produced done", exp_q.size(), 0);
    summary();
  end
endmodule